// File: doc/BRIEF.md
# Per-Core Wake and Quiesce Controller

This block is the per-core slice of an interrupt routing unit that manages the sleep handshake for one core. Software sees one 32-bit control word on a simple memory-mapped port. One bit of that word is a sleep request that software can write. Another bit is a read-only quiescence flag. Once the sleep request is set, the block asks the CPU interface to hand back any interrupts it still holds. It then watches an idle input from the downstream interfaces and reports quiescence when both are done. While the core sleeps, an interrupt that arrives for it is not delivered. Instead it raises a level wake request toward the power controller.

The block rejects two illegal changes of the sleep bit: setting it while any interrupt group is still enabled, and clearing it before quiescence is reported. A rejected write leaves the bit unchanged and sets a sticky error flag. That flag sits in a separate debug word and is cleared by writing 1 to it. The core comes out of reset asleep and quiescent.

Top module: `core_wake_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0006 (sleep bit 1 and quiescent bit 2 both set), the debug word reads 0, and wake_req and release_req are 0.
- R2: Bits 0 and 3..31 of the control word always read 0, and writes to them have no effect. An address that is neither the control word (0x014) nor the debug word (0x018) reads 0.
- R3: A write of 1 to bit 1 of the control word, made while asleep is 0 and every group enable is 0, sets the sleep bit at the next clock edge. From that edge, release_req stays high until an edge at which release_ack is high.
- R4: Control bit 2 reads 1 only when three conditions hold: the sleep bit is 1, the release handshake has finished, and if_idle was high at each of the last IDLE_CYCLES (default 2) rising edges. Bit 2 reads 0 after any edge at which if_idle was low.
- R5: A write of 0 to bit 1, made while bit 2 reads 1, clears the sleep bit at the next edge. Bit 2 then reads 0 in that same cycle.
- R6: A write of 0 to bit 1 while asleep and not quiescent leaves the sleep bit at 1 and sets debug bit 0.
- R7: A write of 1 to bit 1 while awake and with any group enable set leaves the sleep bit at 0 and sets debug bit 0.
- R8: Debug bit 0 stays set until a write to the debug word with data bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R9: An irq_arrive pulse while the sleep bit is 1 is not delivered. wake_req goes high at the next edge and stays high until an accepted clear of the sleep bit.
- R10: While the sleep bit is 0, irq_deliver follows irq_arrive in the same cycle and wake_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset within the per-core frame |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| grp_enable | input | NUM_GROUPS | Group enables reported by the CPU interface |
| if_idle | input | 1 | High when all downstream interfaces are idle |
| release_ack | input | 1 | CPU interface has handed back its pending interrupts |
| release_req | output | 1 | Request to hand back pending interrupts |
| irq_arrive | input | 1 | One-cycle strobe: an interrupt targets this core |
| irq_deliver | output | 1 | Interrupt forwarded to the awake core |
| wake_req | output | 1 | Level wake request to the power controller |

## Verification
Read data and irq_deliver are combinational, so they are due in the same cycle as the address or strobe. The sleep bit, the error flag, release_req and wake_req all change at the first rising edge after the stimulus. Quiescence becomes valid one edge after the acknowledge, as long as the idle window is already full. The bench drives inputs just after the falling edge and compares a quarter period later, before the next rising edge. At that point its reference model holds the state as of the last edge. After each comparison the model is stepped once, so every result is compared in exactly the cycle it is due.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned SLEEP_BIT = 1;
  localparam int unsigned QUIET_BIT = 2;
  localparam int unsigned ERR_BIT = 0;

  // Assemble the visible control word: only sleep and quiet carry data.
  function automatic logic [REG_W-1:0] ctrl_word(input logic sleep, input logic quiet);
    logic [REG_W-1:0] w;
    w = '0;
    w[SLEEP_BIT] = sleep;
    w[QUIET_BIT] = quiet;
    return w;
  endfunction

  // Saturating count of consecutive idle edges.
  function automatic int unsigned idle_step(input int unsigned cnt, input logic idle,
                                            input int unsigned lim);
    if (!idle) return 0;
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction
endpackage

// File: rtl/wake_ctrl_regs.sv
module wake_ctrl_regs
  import wake_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_GROUPS = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h014,
  parameter logic [ADDR_W-1:0] DBG_OFS = 12'h018
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [NUM_GROUPS-1:0] grp_en_i,
  input  logic                  quiesce_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic                  sleep_o,
  output logic                  set_acc_o,
  output logic                  clr_acc_o
);
  logic sleep_q, err_q;
  logic ctrl_wr, dbg_w1c, set_bad, clr_bad;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1:2]};

  assign ctrl_wr   = wr_i && (addr_i == CTRL_OFS);
  assign dbg_w1c   = wr_i && (addr_i == DBG_OFS) && wdata_i[ERR_BIT];
  assign set_acc_o = ctrl_wr && wdata_i[SLEEP_BIT] && !sleep_q && (grp_en_i == '0);
  assign set_bad   = ctrl_wr && wdata_i[SLEEP_BIT] && !sleep_q && (grp_en_i != '0);
  assign clr_acc_o = ctrl_wr && !wdata_i[SLEEP_BIT] && sleep_q && quiesce_i;
  assign clr_bad   = ctrl_wr && !wdata_i[SLEEP_BIT] && sleep_q && !quiesce_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if (set_acc_o) sleep_q <= 1'b1;
      else if (clr_acc_o) sleep_q <= 1'b0;
      if (set_bad || clr_bad) err_q <= 1'b1;
      else if (dbg_w1c) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) rdata_o = ctrl_word(sleep_q, quiesce_i);
    else if (addr_i == DBG_OFS) rdata_o[ERR_BIT] = err_q;
  end

  assign sleep_o = sleep_q;

  assert_clear_needs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> $past(quiesce_i));
  assert_set_needs_groups_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> ($past(grp_en_i) == '0));
  assert_err_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(dbg_w1c));
endmodule

// File: rtl/quiesce_track.sv
module quiesce_track
  import wake_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic set_acc_i,
  input  logic idle_i,
  input  logic ack_i,
  output logic release_req_o,
  output logic quiesce_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] idle_cnt;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= CNT_FULL;
      done_q   <= 1'b1;
    end else begin
      idle_cnt <= CNT_W'(idle_step(int'(idle_cnt), idle_i, IDLE_CYCLES));
      if (set_acc_i) done_q <= 1'b0;
      else if (release_req_o && ack_i) done_q <= 1'b1;
    end
  end

  assign release_req_o = sleep_i && !done_q;
  assign quiesce_o     = sleep_i && done_q && (idle_cnt == CNT_FULL);

  assert_release_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req_o && !ack_i) |=> release_req_o);
  assert_quiet_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiesce_o) |-> $past(idle_i));
endmodule

// File: rtl/wake_req_gen.sv
module wake_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic clr_acc_i,
  input  logic irq_i,
  output logic wake_o,
  output logic deliver_o
);
  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else if (clr_acc_i) wake_q <= 1'b0;
    else if (irq_i && sleep_i) wake_q <= 1'b1;
  end

  assign wake_o    = wake_q;
  assign deliver_o = irq_i && !sleep_i;

  assert_wake_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(sleep_i && irq_i));
endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned IDLE_CYCLES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h014,
  parameter logic [ADDR_W-1:0] DBG_OFS = 12'h018
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_GROUPS-1:0] grp_enable,
  input  logic                  if_idle,
  input  logic                  release_ack,
  output logic                  release_req,
  input  logic                  irq_arrive,
  output logic                  irq_deliver,
  output logic                  wake_req
);
  logic sleep_w, set_acc_w, clr_acc_w, quiet_w;

  wake_ctrl_regs #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
                   .CTRL_OFS(CTRL_OFS), .DBG_OFS(DBG_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .grp_en_i(grp_enable), .quiesce_i(quiet_w), .rdata_o(reg_rdata),
    .sleep_o(sleep_w), .set_acc_o(set_acc_w), .clr_acc_o(clr_acc_w));

  quiesce_track #(.IDLE_CYCLES(IDLE_CYCLES)) u_track (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_w), .set_acc_i(set_acc_w),
    .idle_i(if_idle), .ack_i(release_ack), .release_req_o(release_req),
    .quiesce_o(quiet_w));

  wake_req_gen u_wake (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_w), .clr_acc_i(clr_acc_w),
    .irq_i(irq_arrive), .wake_o(wake_req), .deliver_o(irq_deliver));

  assert_wake_implies_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleep_w);
endmodule

// File: tb/core_wake_ctrl_tb.sv
module core_wake_ctrl_tb;
  localparam logic [11:0] CTRL = 12'h014;
  localparam logic [11:0] DBG  = 12'h018;
  localparam int unsigned IDLE_N = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, if_idle = 1, release_ack = 0, irq_arrive = 0;
  logic [11:0] reg_addr = CTRL;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] grp_enable = '0;
  logic release_req, irq_deliver, wake_req;
  int checks = 0, fails = 0;

  // Reference state as of the last rising edge.
  logic m_sleep, m_done, m_err, m_wake;
  int unsigned m_cnt;

  always #10 clk = ~clk;

  core_wake_ctrl u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_enable(grp_enable),
    .if_idle(if_idle), .release_ack(release_ack), .release_req(release_req),
    .irq_arrive(irq_arrive), .irq_deliver(irq_deliver), .wake_req(wake_req));

  function automatic logic quiet_of();
    return m_sleep && m_done && (m_cnt >= IDLE_N);
  endfunction

  function automatic logic [31:0] read_of(input logic [11:0] a);
    if (a == CTRL) return {29'd0, quiet_of(), m_sleep, 1'b0};
    if (a == DBG) return {31'd0, m_err};
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare outputs a quarter period after the drive, then step the model across the edge.
  task automatic tick();
    logic set_ok, set_bad, clr_ok, clr_bad, q;
    #5;
    chk(reg_addr == CTRL ? "R4 ctrl read" : reg_addr == DBG ? "R8 dbg read" : "R2 other read",
        reg_rdata, read_of(reg_addr));
    chk("R3 release_req", {31'd0, release_req}, {31'd0, m_sleep && !m_done});
    chk("R9 wake_req", {31'd0, wake_req}, {31'd0, m_wake});
    chk("R10 irq_deliver", {31'd0, irq_deliver}, {31'd0, irq_arrive && !m_sleep});
    q       = quiet_of();
    set_ok  = reg_wr && reg_addr == CTRL && reg_wdata[1] && !m_sleep && grp_enable == 0;
    set_bad = reg_wr && reg_addr == CTRL && reg_wdata[1] && !m_sleep && grp_enable != 0;
    clr_ok  = reg_wr && reg_addr == CTRL && !reg_wdata[1] && m_sleep && q;
    clr_bad = reg_wr && reg_addr == CTRL && !reg_wdata[1] && m_sleep && !q;
    if (set_ok) m_done = 0;
    else if (m_sleep && !m_done && release_ack) m_done = 1;
    m_cnt = if_idle ? ((m_cnt >= IDLE_N) ? IDLE_N : m_cnt + 1) : 0;
    if (set_bad || clr_bad) m_err = 1;
    else if (reg_wr && reg_addr == DBG && reg_wdata[0]) m_err = 0;
    if (clr_ok) m_wake = 0;
    else if (irq_arrive && m_sleep) m_wake = 1;
    if (set_ok) m_sleep = 1;
    else if (clr_ok) m_sleep = 0;
    @(negedge clk);
  endtask

  task automatic quiet_in();
    reg_wr = 0; irq_arrive = 0; release_ack = 0;
  endtask

  task automatic peek(input string req, input logic [11:0] a, input logic [31:0] exp);
    quiet_in(); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    quiet_in(); reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); quiet_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'd1234;
    r = $urandom(seed);
    m_sleep = 1; m_done = 1; m_err = 0; m_wake = 0; m_cnt = IDLE_N;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek("R1 ctrl after reset", CTRL, 32'h6);
    peek("R1 dbg after reset", DBG, 32'h0);
    chk("R1 wake_req", {31'd0, wake_req}, 32'd0);
    chk("R1 release_req", {31'd0, release_req}, 32'd0);
    // R5 and R2: legal clear with reserved bits set
    wr(CTRL, 32'hFFFF_FFF9);
    peek("R5 R2 ctrl after clear", CTRL, 32'h0);
    peek("R2 unmapped address", 12'h010, 32'h0);
    // R10: delivery while awake
    irq_arrive = 1; #1;
    chk("R10 deliver awake", {31'd0, irq_deliver}, 32'd1);
    tick(); quiet_in();
    chk("R10 no wake awake", {31'd0, wake_req}, 32'd0);
    // R7: set with a group enabled
    grp_enable = 2'b01;
    wr(CTRL, 32'h2);
    grp_enable = 2'b00;
    peek("R7 sleep stays 0", CTRL, 32'h0);
    peek("R7 err set", DBG, 32'h1);
    // R8: W1C semantics
    wr(DBG, 32'h0);
    peek("R8 err kept on 0 write", DBG, 32'h1);
    wr(DBG, 32'h1);
    peek("R8 err cleared", DBG, 32'h0);
    // R3: legal set starts release
    wr(CTRL, 32'h2);
    chk("R3 release_req high", {31'd0, release_req}, 32'd1);
    peek("R4 not quiet before ack", CTRL, 32'h2);
    // R6: clear before quiescence
    wr(CTRL, 32'h0);
    peek("R6 sleep kept", CTRL, 32'h2);
    peek("R6 err set", DBG, 32'h1);
    wr(DBG, 32'h1);
    release_ack = 1; tick(); quiet_in();
    chk("R3 release_req dropped", {31'd0, release_req}, 32'd0);
    peek("R4 quiet after ack", CTRL, 32'h6);
    // R4: idle window
    if_idle = 0; tick(); if_idle = 1;
    peek("R4 idle low drops quiet", CTRL, 32'h2);
    tick();
    peek("R4 one idle edge", CTRL, 32'h2);
    tick();
    peek("R4 two idle edges", CTRL, 32'h6);
    // R9: wake while asleep
    irq_arrive = 1; #1;
    chk("R10 no deliver asleep", {31'd0, irq_deliver}, 32'd0);
    tick(); quiet_in();
    chk("R9 wake raised", {31'd0, wake_req}, 32'd1);
    tick();
    chk("R9 wake held", {31'd0, wake_req}, 32'd1);
    wr(CTRL, 32'h0);
    chk("R9 wake cleared", {31'd0, wake_req}, 32'd0);
    peek("R5 quiet drops with sleep", CTRL, 32'h0);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom();
      reg_wr = (r[3:0] < 5);
      reg_addr = (r[7:4] < 10) ? CTRL : (r[7:4] < 14) ? DBG : 12'h010;
      reg_wdata = $urandom();
      grp_enable = (r[11:8] < 11) ? 2'b00 : r[13:12];
      if_idle = (r[17:14] < 13);
      release_ack = r[18];
      irq_arrive = (r[23:20] < 4);
      tick();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule